// File: doc/BRIEF.md
# Coherent Transaction Event Counters

This block is a small bank of performance counters, one instance per processor cluster. It watches three coherent traffic sources: the outbound memory request channel, the inbound snoop channel, and the write channel into a coherent accelerator port. Each source presents a 4-bit opcode and a valid strobe on every cycle. Four counters each add up a fixed family of opcodes from one source:

- memory writes
- memory reads
- snoop reads
- accelerator-port writes

The snoop-read family also includes the read-once opcode, which the memory-read family leaves out.

Software controls the bank through a flat register port. A write to the control address does three things at once: it sets the per-counter enable bits, it sets the per-counter interrupt-enable bits, and it can pulse a clear into any counter. Reads return the counter values, the control settings and the sticky overflow flags. The interrupt output is a single active-high level. It stays high while any counter has an overflow flag set and its interrupt enable on.

Top module: `coh_evt_counters`

## Requirements
- R1: After a synchronous active-high reset, every counter reads 0, all enables and interrupt enables read 0, all overflow flags read 0, and `irq` is low.
- R2: The opcode encoding is 0 idle, 1 read-once, 2 read-shared, 3 read-unique, 4 read-clean, 5 read-not-shared-dirty, 6 write-back, 7 write-clean, 8 write-evict, 9 write-unique. Values 9 to 15 belong to no counter's family.
- R3: Counter 0 (memory writes) adds one for each cycle in which `mem_vld` is high and `mem_op` is 6, 7 or 8.
- R4: Counter 1 (memory reads) adds one for each cycle in which `mem_vld` is high and `mem_op` is 2, 3, 4 or 5. Read-once (1) on the memory channel is not counted.
- R5: Counter 2 (snoop reads) adds one for each cycle in which `snp_vld` is high and `snp_op` is 1, 2, 3, 4 or 5. Write opcodes on the snoop channel are not counted.
- R6: Counter 3 (accelerator-port writes) adds one for each cycle in which `acp_vld` is high and `acp_op` is 6, 7 or 8.
- R7: An opcode with its valid strobe low, or an opcode outside a counter's family, changes no counter. A counter advances by at most one per cycle.
- R8: While a counter's enable bit is 0, that counter holds its value. An increment in the same cycle as a control write uses the enable value held before the write.
- R9: A control write with clear bit i set zeroes counter i and its overflow flag. The clear wins over an increment in the same cycle.
- R10: An increment from the all-ones value wraps the counter to 0 and sets its overflow flag. The flag stays set through later increments until a clear.
- R11: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R12: Register map on `cfg_addr`. Addresses 0 to 3 read counters 0 to 3, zero-extended to 32 bits. Address 4 is control: bits 3:0 are the enables, bits 7:4 are the clear pulses (they read back as 0), bits 11:8 are the interrupt enables. Address 5 reads the overflow flags in bits 3:0. All other addresses read 0. `cfg_rdata` follows `cfg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_vld | input | 1 | Memory request channel transaction valid |
| mem_op | input | 4 | Memory request channel opcode |
| snp_vld | input | 1 | Inbound snoop channel transaction valid |
| snp_op | input | 4 | Inbound snoop channel opcode |
| acp_vld | input | 1 | Accelerator-port write channel valid |
| acp_op | input | 4 | Accelerator-port write channel opcode |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data (control fields) |
| cfg_rdata | output | 32 | Register read data, combinational on `cfg_addr` |
| irq | output | 1 | Level interrupt, active high |

## Verification
A miscounted or misdecoded opcode shows up in the matching counter's readback on the cycle after the transaction. The bench reads every counter after each stimulus vector, so a wrong family membership is caught within one cycle of the offending opcode. A lost or stuck overflow flag shows at the status address and on `irq` one cycle after the wrapping increment. A clear that loses to an increment leaves a nonzero count visible at the next read.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;

    localparam int NUM_CNT  = 4;
    localparam int OP_W     = 4;
    localparam int ADDR_W   = 3;
    localparam int RDATA_W  = 32;
    localparam int EN_LSB   = 0;
    localparam int CLR_LSB  = EN_LSB + NUM_CNT;
    localparam int IEN_LSB  = CLR_LSB + NUM_CNT;
    localparam int CTRL_W   = IEN_LSB + NUM_CNT;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(5);

    // counter slots
    localparam int IDX_MEM_WR = 0;
    localparam int IDX_MEM_RD = 1;
    localparam int IDX_SNP_RD = 2;
    localparam int IDX_ACP_WR = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE      = 4'd0,
        OP_RD_ONCE   = 4'd1,
        OP_RD_SHARED = 4'd2,
        OP_RD_UNIQUE = 4'd3,
        OP_RD_CLEAN  = 4'd4,
        OP_RD_NSD    = 4'd5,
        OP_WR_BACK   = 4'd6,
        OP_WR_CLEAN  = 4'd7,
        OP_WR_EVICT  = 4'd8,
        OP_WR_UNIQUE = 4'd9
    } coh_op_e;

    typedef struct packed {
        logic    vld;
        coh_op_e op;
    } coh_txn_t;

    // write-back family: shared by memory writes and accelerator writes
    function automatic logic op_is_wb_family(coh_op_e op);
        case (op)
            OP_WR_BACK, OP_WR_CLEAN, OP_WR_EVICT: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

    // reads that go out to memory (no read-once)
    function automatic logic op_is_mem_read(coh_op_e op);
        case (op)
            OP_RD_SHARED, OP_RD_UNIQUE, OP_RD_CLEAN, OP_RD_NSD: return 1'b1;
            default:                                            return 1'b0;
        endcase
    endfunction

    // reads snooped into the cluster (memory reads plus read-once)
    function automatic logic op_is_snoop_read(coh_op_e op);
        return (op == OP_RD_ONCE) || op_is_mem_read(op);
    endfunction

endpackage

// File: rtl/coh_evt_decode.sv
module coh_evt_decode
    import coh_evt_pkg::*;
(
    input  coh_txn_t               mem_txn,
    input  coh_txn_t               snp_txn,
    input  coh_txn_t               acp_txn,
    output logic [NUM_CNT-1:0]     hit
);

    always_comb begin
        hit             = '0;
        hit[IDX_MEM_WR] = mem_txn.vld && op_is_wb_family(mem_txn.op);
        hit[IDX_MEM_RD] = mem_txn.vld && op_is_mem_read(mem_txn.op);
        hit[IDX_SNP_RD] = snp_txn.vld && op_is_snoop_read(snp_txn.op);
        hit[IDX_ACP_WR] = acp_txn.vld && op_is_wb_family(acp_txn.op);
    end

    // R7: one memory-channel transaction can never feed both memory counters
    always_comb begin
        p_mem_exclusive_r7: assert (!(hit[IDX_MEM_WR] && hit[IDX_MEM_RD]))
            else $error("memory channel hit both read and write counters");
    end

endmodule

// File: rtl/coh_evt_counter.sv
module coh_evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en && inc) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_MAX) ovf <= 1'b1;
        end
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0) && !ovf);

    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));

    p_step_one_r7: assert property (@(posedge clk) disable iff (rst)
        (en && inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1));

    p_wrap_sets_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (en && inc && !clr && cnt == CNT_MAX) |=> (cnt == '0) && ovf);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

endmodule

// File: rtl/coh_evt_regs.sv
module coh_evt_regs
    import coh_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [CTRL_W-1:0]               cfg_wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
    input  logic [NUM_CNT-1:0]              ovf,
    output logic [NUM_CNT-1:0]              en,
    output logic [NUM_CNT-1:0]              clr,
    output logic [RDATA_W-1:0]              cfg_rdata,
    output logic                            irq
);

    logic                ctrl_wr;
    logic [NUM_CNT-1:0]  ien;

    assign ctrl_wr = cfg_we && (cfg_addr == ADDR_CTRL);
    assign clr     = {NUM_CNT{ctrl_wr}} & cfg_wdata[CLR_LSB +: NUM_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            ien <= '0;
        end else if (ctrl_wr) begin
            en  <= cfg_wdata[EN_LSB  +: NUM_CNT];
            ien <= cfg_wdata[IEN_LSB +: NUM_CNT];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cfg_addr == ADDR_W'(i)) cfg_rdata = RDATA_W'(cnt[i]);
        end
        if (cfg_addr == ADDR_CTRL) begin
            cfg_rdata[EN_LSB  +: NUM_CNT] = en;
            cfg_rdata[IEN_LSB +: NUM_CNT] = ien;
        end
        if (cfg_addr == ADDR_STAT) cfg_rdata[NUM_CNT-1:0] = ovf;
    end

    assign irq = |(ovf & ien);

    p_irq_has_source_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf != '0));

    p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !cfg_we) |=> irq);

endmodule

// File: rtl/coh_evt_counters.sv
module coh_evt_counters
    import coh_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mem_vld,
    input  logic [OP_W-1:0]       mem_op,
    input  logic                  snp_vld,
    input  logic [OP_W-1:0]       snp_op,
    input  logic                  acp_vld,
    input  logic [OP_W-1:0]       acp_op,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CTRL_W-1:0]     cfg_wdata,
    output logic [RDATA_W-1:0]    cfg_rdata,
    output logic                  irq
);

    coh_txn_t                       mem_txn, snp_txn, acp_txn;
    logic [NUM_CNT-1:0]             hit;
    logic [NUM_CNT-1:0]             en;
    logic [NUM_CNT-1:0]             clr;
    logic [NUM_CNT-1:0]             ovf;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;

    assign mem_txn = '{vld: mem_vld, op: coh_op_e'(mem_op)};
    assign snp_txn = '{vld: snp_vld, op: coh_op_e'(snp_op)};
    assign acp_txn = '{vld: acp_vld, op: coh_op_e'(acp_op)};

    coh_evt_decode u_decode (
        .mem_txn (mem_txn),
        .snp_txn (snp_txn),
        .acp_txn (acp_txn),
        .hit     (hit)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        coh_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .en  (en[g]),
            .inc (hit[g]),
            .clr (clr[g]),
            .cnt (cnt[g]),
            .ovf (ovf[g])
        );
    end

    coh_evt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cnt       (cnt),
        .ovf       (ovf),
        .en        (en),
        .clr       (clr),
        .cfg_rdata (cfg_rdata),
        .irq       (irq)
    );

    // R1: nothing is pending on the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && ovf == '0));

endmodule

// File: tb/tb_coh_evt_counters.sv
module tb_coh_evt_counters;

    localparam int W = 8;   // narrow counters so that a wrap is reachable

    logic        clk = 1'b0;
    logic        rst;
    logic        mem_vld, snp_vld, acp_vld;
    logic [3:0]  mem_op, snp_op, acp_op;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [11:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    int exp_cnt [4];
    logic [31:0] rd;

    always #5 clk = ~clk;

    coh_evt_counters #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst),
        .mem_vld(mem_vld), .mem_op(mem_op),
        .snp_vld(snp_vld), .snp_op(snp_op),
        .acp_vld(acp_vld), .acp_op(acp_op),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    // {mem_vld, mem_op, snp_vld, snp_op, acp_vld, acp_op, delta[acp,snp,mrd,mwr]}
    // opcodes per R2: 1 RO, 2 RS, 3 RU, 4 RC, 5 RNSD, 6 WB, 7 WC, 8 WE, 9 WU
    localparam int NV = 11;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 4'd6, 1'b0, 4'd0, 1'b0, 4'd0, 4'b0001},
        {1'b1, 4'd8, 1'b1, 4'd1, 1'b1, 4'd7, 4'b1101},
        {1'b1, 4'd5, 1'b1, 4'd5, 1'b0, 4'd0, 4'b0110},
        {1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0, 4'b0000},
        {1'b1, 4'd2, 1'b0, 4'd0, 1'b1, 4'd9, 4'b0010},
        {1'b0, 4'd7, 1'b0, 4'd3, 1'b0, 4'd6, 4'b0000},
        {1'b0, 4'd0, 1'b1, 4'd6, 1'b0, 4'd0, 4'b0000},
        {1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd4, 4'b0000},
        {1'b1, 4'd3, 1'b1, 4'd4, 1'b1, 4'd8, 4'b1110},
        {1'b1, 4'd4, 1'b1, 4'd2, 1'b1, 4'd6, 4'b1110},
        {1'b1, 4'd0, 1'b1, 4'd15,1'b1, 4'd11,4'b0000}
    };

    function automatic string cname(int i);
        case (i)
            0: return "R3 mem-write";
            1: return "R4 mem-read";
            2: return "R5 snoop-read";
            default: return "R6 acp-write";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // read during the low phase, well before the next rising edge
    task automatic rd_reg(logic [2:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic ctrl_wr(logic [3:0] en, logic [3:0] clr, logic [3:0] ien);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = {ien, clr, en};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_src();
        mem_vld = 1'b0; snp_vld = 1'b0; acp_vld = 1'b0;
        mem_op = '0; snp_op = '0; acp_op = '0;
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(i), rd);
            chk({cname(i), " ", tag}, rd, 32'(exp_cnt[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        idle_src();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            rd_reg(3'(i), rd); chk("R1 counter zero", rd, 32'h0);
        end
        rd_reg(3'd4, rd); chk("R1 control zero", rd, 32'h0);
        rd_reg(3'd5, rd); chk("R1 overflow zero", rd, 32'h0);
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // R12: control readback (clear bits read as zero), unused address
        ctrl_wr(4'hF, 4'h0, 4'h0);
        rd_reg(3'd4, rd); chk("R12 control readback", rd, 32'h00F);
        rd_reg(3'd6, rd); chk("R12 unused address", rd, 32'h0);

        // table walk, R3-R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {mem_vld, mem_op, snp_vld, snp_op, acp_vld, acp_op} = VEC[v][18:4];
            @(negedge clk);
            idle_src();
            for (int i = 0; i < 4; i++) exp_cnt[i] += int'(VEC[v][i]);
            check_all($sformatf("R7 vec%0d", v));
        end

        // R8: only counter 0 enabled, all sources active for one cycle
        ctrl_wr(4'h1, 4'h0, 4'h0);
        @(negedge clk);
        mem_vld = 1'b1; mem_op = 4'd6; snp_vld = 1'b1; snp_op = 4'd2;
        acp_vld = 1'b1; acp_op = 4'd7;
        @(negedge clk);
        idle_src();
        exp_cnt[0] += 1;
        check_all("R8 disabled hold");

        // R8: increment coincident with the enabling write uses the old enable
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 12'h00F;
        snp_vld = 1'b1; snp_op = 4'd1;
        @(negedge clk);
        cfg_we = 1'b0; idle_src();
        check_all("R8 old enable");

        // R9: clear counter 0 while it is being incremented
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 12'h01F;
        mem_vld = 1'b1; mem_op = 4'd7;
        @(negedge clk);
        cfg_we = 1'b0; idle_src();
        exp_cnt[0] = 0;
        check_all("R9 clear wins");

        // R10/R11: wrap counter 0 with its interrupt enabled
        ctrl_wr(4'h1, 4'h1, 4'h1);
        @(negedge clk);
        mem_vld = 1'b1; mem_op = 4'd8;
        repeat (255) @(negedge clk);
        idle_src();
        rd_reg(3'd0, rd); chk("R10 at max", rd, 32'hFF);
        rd_reg(3'd5, rd); chk("R10 no flag before wrap", rd, 32'h0);
        chk("R11 irq low before wrap", {31'b0, irq}, 32'h0);
        @(negedge clk);
        mem_vld = 1'b1; mem_op = 4'd6;
        @(negedge clk);
        idle_src();
        rd_reg(3'd0, rd); chk("R10 wrapped to zero", rd, 32'h0);
        rd_reg(3'd5, rd); chk("R10 flag set", rd, 32'h1);
        chk("R11 irq high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        mem_vld = 1'b1; mem_op = 4'd6;
        @(negedge clk);
        idle_src();
        rd_reg(3'd0, rd); chk("R10 counts on", rd, 32'h1);
        rd_reg(3'd5, rd); chk("R10 flag sticky", rd, 32'h1);
        chk("R11 irq held", {31'b0, irq}, 32'h1);

        // R11: mask the interrupt, flag still set
        ctrl_wr(4'h1, 4'h0, 4'h0);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        rd_reg(3'd5, rd); chk("R11 flag kept when masked", rd, 32'h1);
        ctrl_wr(4'h1, 4'h0, 4'h1);
        chk("R11 irq unmasked", {31'b0, irq}, 32'h1);

        // R9: clear drops the flag and the interrupt
        ctrl_wr(4'h1, 4'h1, 4'h1);
        rd_reg(3'd5, rd); chk("R9 flag cleared", rd, 32'h0);
        rd_reg(3'd0, rd); chk("R9 count cleared", rd, 32'h0);
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule